// File: doc/BRIEF.md
# ADC Sample Output Formatter

This block sits at the end of an ADC sample path and reshapes each 16-bit sample before it leaves the chip. It adds a signed trim in LSBs, can optionally negate the sample, and then codes it as either two's complement or offset binary. All arithmetic saturates instead of wrapping. The result is registered once, so a sample presented with its valid strobe appears one clock later.

The trim, invert and coding controls are plain inputs driven by the surrounding configuration logic. That logic should reset the trim to zero, the invert control to off and the coding select to two's complement. The incoming sample is always two's complement.

Top module: `adc_out_formatter`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 16'h0000.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock.
- R3: With invert off and `code_twos`=1, a valid sample produces `in_sample` + sign-extended `trim` (trim is two's complement, -128 to +127) one clock later.
- R4: A sum above +32767 is clamped to 16'h7FFF.
- R5: A sum below -32768 is clamped to 16'h8000.
- R6: With `invert`=1, the trimmed value is arithmetically negated, and -32768 becomes +32767 (16'h7FFF).
- R7: `code_twos`=1 outputs two's complement; `code_twos`=0 outputs offset binary, which is the two's-complement result with bit 15 flipped.
- R8: While `in_valid` is 0, `out_data` keeps its previous value.
- R9: The trim is applied and saturated first, negation follows, and coding is applied last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Two's-complement input sample |
| trim | input | 8 | Signed offset trim in LSBs |
| invert | input | 1 | 1 = negate the trimmed sample |
| code_twos | input | 1 | 1 = two's complement, 0 = offset binary |
| out_valid | output | 1 | Output strobe, one clock after `in_valid` |
| out_data | output | 16 | Formatted sample |

## Verification
The vector table covers three trim cases: zero trim, a small positive trim and the most negative trim. These distinguish a correct sign extension from a zero extension. Pairs of near-full-scale samples with trims of the same sign drive both clamps, which a wrapping adder would get wrong. Invert vectors put the trim and the negation on the same sample, so a design that applies them in the wrong order gives a different value. Applying offset-binary coding to both extremes and to zero-crossing values separates a flip of bit 15 from a full bit inversion.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    localparam int unsigned SAMPLE_W_DEF = 16;
    localparam int unsigned TRIM_W_DEF   = 8;

    typedef enum logic {
        CODE_OFFSET_BIN = 1'b0,
        CODE_TWOS_COMP  = 1'b1
    } code_sel_e;
endpackage

// File: rtl/fmt_trim_add.sv
module fmt_trim_add #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned TRIM_W   = 8
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [TRIM_W-1:0]   trim_i,
    output logic [SAMPLE_W-1:0] sum_o
);
    localparam int unsigned          EXT_W = SAMPLE_W + 1;
    localparam logic [SAMPLE_W-1:0] POS_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] b_ext;
    logic [EXT_W-1:0] wide_sum;

    always_comb begin
        a_ext    = {sample_i[SAMPLE_W-1], sample_i};
        b_ext    = {{(EXT_W-TRIM_W){trim_i[TRIM_W-1]}}, trim_i};
        wide_sum = a_ext + b_ext;
        if (wide_sum[EXT_W-1] != wide_sum[EXT_W-2]) begin
            sum_o = wide_sum[EXT_W-1] ? NEG_MIN : POS_MAX;
        end else begin
            sum_o = wide_sum[SAMPLE_W-1:0];
        end
    end
endmodule

// File: rtl/fmt_negate.sv
module fmt_negate #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic                en_i,
    input  logic [SAMPLE_W-1:0] val_i,
    output logic [SAMPLE_W-1:0] val_o
);
    localparam logic [SAMPLE_W-1:0] POS_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    always_comb begin
        if (!en_i) begin
            val_o = val_i;
        end else if (val_i == NEG_MIN) begin
            val_o = POS_MAX;
        end else begin
            val_o = (~val_i) + {{(SAMPLE_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/fmt_encode.sv
module fmt_encode #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  fmt_pkg::code_sel_e  code_i,
    input  logic [SAMPLE_W-1:0] val_i,
    output logic [SAMPLE_W-1:0] val_o
);
    always_comb begin
        if (code_i == fmt_pkg::CODE_TWOS_COMP) begin
            val_o = val_i;
        end else begin
            val_o = {~val_i[SAMPLE_W-1], val_i[SAMPLE_W-2:0]};
        end
    end
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter #(
    parameter int unsigned SAMPLE_W = fmt_pkg::SAMPLE_W_DEF,
    parameter int unsigned TRIM_W   = fmt_pkg::TRIM_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [TRIM_W-1:0]   trim,
    input  logic                invert,
    input  logic                code_twos,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);
    localparam logic [SAMPLE_W-1:0] POS_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};

    typedef struct packed {
        logic                vld;
        logic [SAMPLE_W-1:0] data;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [SAMPLE_W-1:0] trimmed_w;
    logic [SAMPLE_W-1:0] signed_w;
    logic [SAMPLE_W-1:0] coded_w;
    fmt_pkg::code_sel_e  code_sel;

    assign code_sel = code_twos ? fmt_pkg::CODE_TWOS_COMP : fmt_pkg::CODE_OFFSET_BIN;

    fmt_trim_add #(.SAMPLE_W(SAMPLE_W), .TRIM_W(TRIM_W)) u_trim (
        .sample_i (in_sample),
        .trim_i   (trim),
        .sum_o    (trimmed_w)
    );

    fmt_negate #(.SAMPLE_W(SAMPLE_W)) u_neg (
        .en_i  (invert),
        .val_i (trimmed_w),
        .val_o (signed_w)
    );

    fmt_encode #(.SAMPLE_W(SAMPLE_W)) u_enc (
        .code_i (code_sel),
        .val_i  (signed_w),
        .val_o  (coded_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = coded_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R4
    no_pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !invert && code_twos && !in_sample[SAMPLE_W-1] && !trim[TRIM_W-1])
        |=> !out_data[SAMPLE_W-1]);

    // R5
    no_neg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !invert && code_twos && in_sample[SAMPLE_W-1] && trim[TRIM_W-1])
        |=> out_data[SAMPLE_W-1]);

    // R6
    neg_min_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && invert && code_twos && in_sample == NEG_MIN && trim == '0)
        |=> out_data == POS_MAX);
endmodule

// File: tb/adc_out_formatter_test.sv
module adc_out_formatter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] in_sample;
    logic [7:0]  trim;
    logic        invert;
    logic        code_twos;
    logic        out_valid;
    logic [15:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    adc_out_formatter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .trim(trim), .invert(invert), .code_twos(code_twos),
        .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [15:0] smp;
        logic [7:0]  trm;
        logic        inv;
        logic        twos;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 16'h1234, 8'h00, 1'b0, 1'b1, 16'h1234}, // R3 zero trim
        '{4'd3, 16'h1234, 8'h05, 1'b0, 1'b1, 16'h1239}, // R3 positive trim
        '{4'd3, 16'h0010, 8'h80, 1'b0, 1'b1, 16'hFF90}, // R3 trim -128
        '{4'd4, 16'h7FF0, 8'h7F, 1'b0, 1'b1, 16'h7FFF}, // R4 clamp high
        '{4'd5, 16'h8005, 8'h80, 1'b0, 1'b1, 16'h8000}, // R5 clamp low
        '{4'd6, 16'h0100, 8'h00, 1'b1, 1'b1, 16'hFF00}, // R6 negate
        '{4'd6, 16'h8000, 8'h00, 1'b1, 1'b1, 16'h7FFF}, // R6 negate min
        '{4'd9, 16'h0100, 8'h10, 1'b1, 1'b1, 16'hFEF0}, // R9 trim then negate
        '{4'd9, 16'h7FFF, 8'h01, 1'b1, 1'b1, 16'h8001}, // R9 clamp then negate
        '{4'd7, 16'h1234, 8'h00, 1'b0, 1'b0, 16'h9234}, // R7 offset binary
        '{4'd7, 16'h8000, 8'h00, 1'b0, 1'b0, 16'h0000}, // R7 most negative
        '{4'd7, 16'hFFFF, 8'h00, 1'b0, 1'b0, 16'h7FFF}, // R7 minus one
        '{4'd9, 16'h8000, 8'h80, 1'b1, 1'b0, 16'hFFFF}  // R9 clamp, negate, code
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] held;
        rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; trim = '0; invert = 1'b0; code_twos = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {15'd0, out_valid}, 16'h0000);
        check("R1 data", out_data, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sample = VECS[i].smp; trim = VECS[i].trm;
            invert = VECS[i].inv; code_twos = VECS[i].twos;
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), out_data, VECS[i].exp);
            check("R2 valid high", {15'd0, out_valid}, 16'h0001);
        end

        // R8 hold while idle, R2 valid drops one clock later
        held = out_data;
        @(negedge clk);
        in_valid = 1'b0; in_sample = 16'h4444; trim = 8'h11; invert = 1'b0; code_twos = 1'b1;
        @(negedge clk);
        check("R2 valid low", {15'd0, out_valid}, 16'h0000);
        check("R8 hold", out_data, held);
        @(negedge clk);
        check("R8 hold later", out_data, held);

        // R2 single pulse
        in_valid = 1'b1; in_sample = 16'h0001; trim = 8'hFF;
        @(negedge clk);
        in_valid = 1'b0;
        check("R3 trim -1", out_data, 16'h0000);
        check("R2 pulse", {15'd0, out_valid}, 16'h0001);
        @(negedge clk);
        check("R2 pulse end", {15'd0, out_valid}, 16'h0000);

        // R1 reset mid-run
        in_valid = 1'b1; in_sample = 16'h5555; trim = 8'h00;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rerun valid", {15'd0, out_valid}, 16'h0000);
        check("R1 rerun data", out_data, 16'h0000);

        done = 1'b1;
        summary();
    end
endmodule